// File: doc/BRIEF.md
# Dual-Lane Converter Output Stage

This block is the digital back end of a two-lane sampling converter. Each clock edge it can take one corrected 10-bit code per lane, together with a shared sample strobe. It carries both codes through a fixed-latency register pipeline and drives them onto two parallel output buses. A single data-valid flag marks the cycles that carry a fresh word. The buses are modelled as data plus a per-bit drive enable, so a pad ring can build the three-state pins from them.

Four static control levels shape the output:
- A coding select chooses between offset binary and two's complement.
- An active-low enable turns the bus drivers on or off.
- A sleep level stops new samples from entering.
- A power-down level freezes the output register completely.

Power-down outranks sleep. The enable only gates the drivers and never touches the stored word.

Top module: `adc_oif_top`

## Requirements
- R1: Lanes A and B are carried in parallel without mixing. Bit 9 of each code and bus is the most significant bit, and each bus shows only its own lane's code.
- R2: With `fmt_tc` low, a word appears unchanged (offset binary). With `fmt_tc` high, bit 9 is inverted and bits 8..0 pass unchanged (two's complement), so code 0x000 gives 0x200 and code 0x3FF gives 0x1FF.
- R3: A code taken with `smp_valid` high at rising edge k is on the bus from just after edge k+4, so a receiver capturing at edge k+5 takes it. `data_valid` is high for exactly that cycle.
- R4: In a cycle with no fresh word, `data_valid` is low and the buses keep the last word they carried.
- R5: With `oe_n` high, every bit of `drv_a` and `drv_b` is 0. With `oe_n` low, every bit is 1. `oe_n` never changes `data_a` or `data_b`.
- R6: While `pd` is high at an edge, that edge leaves both buses unchanged. This holds for a word arriving from the pipeline and for a `fmt_tc` change. `data_valid` is 0 after that edge.
- R7: While `sleep` is high, samples at the input and samples already in the pipeline are discarded, and `data_valid` stays 0. A `fmt_tc` change still recodes the held word at the next edge.
- R8: After sleep or power-down is released, `data_valid` stays low until the first sample taken at or after the release edge has passed the full latency of R3.
- R9: With both `pd` and `sleep` high, power-down behaviour (R6) applies.
- R10: A `fmt_tc` change reaches the bus at the next rising edge and not before.
- R11: After reset both buses are 0x000 and `data_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Both lane codes hold a new sample this edge |
| code_a | input | 10 | Corrected offset-binary code, lane A |
| code_b | input | 10 | Corrected offset-binary code, lane B |
| fmt_tc | input | 1 | 1 selects two's complement, 0 offset binary |
| oe_n | input | 1 | Active-low output drive enable |
| sleep | input | 1 | Halts sampling, discards in-flight samples |
| pd | input | 1 | Freezes output register |
| data_a | output | 10 | Output word, lane A |
| data_b | output | 10 | Output word, lane B |
| drv_a | output | 10 | Per-bit drive enable, lane A |
| drv_b | output | 10 | Per-bit drive enable, lane B |
| data_valid | output | 1 | Bus carries a fresh word this cycle |

## Verification
In one edge, a sample may reach the end of the pipeline while power-down is asserted, and a coding change may coincide with a held word being recoded or frozen. The bench provokes the first case by raising `pd` in the cycle just before a sent sample is due. It judges the result by the bus keeping its previous word and `data_valid` staying low. For the second case it toggles `fmt_tc` under sleep alone and under sleep with power-down. It expects a recoded word in the first case and an unchanged word in the second.

// File: rtl/adc_oif_pkg.sv
package adc_oif_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_PDOWN = 2'd2
  } oif_mode_e;

  // power-down outranks sleep
  function automatic oif_mode_e pick_mode(input logic sleep_i, input logic pd_i);
    if (pd_i)         return MODE_PDOWN;
    else if (sleep_i) return MODE_SLEEP;
    else              return MODE_RUN;
  endfunction

endpackage

// File: rtl/adc_oif_valid.sv
module adc_oif_valid
  import adc_oif_pkg::*;
#(
  parameter int LAT = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_valid,
  input  oif_mode_e mode,
  output logic      load_word,
  output logic      dvalid
);
  localparam int DEPTH = LAT - 1;

  logic [DEPTH-1:0] vchain;
  logic             tail_v;

  assign tail_v    = vchain[DEPTH-1];
  assign load_word = tail_v && (mode == MODE_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vchain <= '0;
      dvalid <= 1'b0;
    end else begin
      if (mode != MODE_RUN) vchain <= '0;
      else                  vchain <= {vchain[DEPTH-2:0], smp_valid};
      dvalid <= load_word;
    end
  end

  // R3: a fresh word on the bus came out of the tail stage one edge earlier
  a_r3_valid_from_tail: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(tail_v));

  // R7: any non-run mode empties the sample chain
  a_r7_chain_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_RUN) |=> (vchain == '0));
endmodule

// File: rtl/adc_oif_lane.sv
module adc_oif_lane #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_tail
);
  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)      stage[g] <= '0;
        else if (g == 0) stage[g] <= code_in;
        else             stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign code_tail = stage[DEPTH-1];
endmodule

// File: rtl/adc_oif_out.sv
module adc_oif_out
  import adc_oif_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  oif_mode_e    mode,
  input  logic         fmt_tc,
  input  logic         load_word,
  input  logic [W-1:0] code_tail,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  // two's complement from offset binary: flip the top bit only
  function automatic logic [W-1:0] recode(input logic [W-1:0] ob, input logic tc);
    return tc ? (ob ^ MSB_MASK) : ob;
  endfunction

  logic [W-1:0] raw_q;
  logic [W-1:0] dout_q;
  logic         frozen;

  assign frozen = (mode == MODE_PDOWN);
  assign dout   = dout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      dout_q <= '0;
    end else if (!frozen) begin
      if (load_word) begin
        raw_q  <= code_tail;
        dout_q <= recode(code_tail, fmt_tc);
      end else begin
        dout_q <= recode(raw_q, fmt_tc);
      end
    end
  end

  // R6: power-down leaves the output word untouched
  a_r6_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(dout_q));

  // R2: coding never alters the low bits of the stored word
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !load_word) |=> (dout_q[W-2:0] == $past(raw_q[W-2:0])));
endmodule

// File: rtl/adc_oif_top.sv
module adc_oif_top
  import adc_oif_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int LAT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              fmt_tc,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              pd,
  output logic [CODE_W-1:0] data_a,
  output logic [CODE_W-1:0] data_b,
  output logic [CODE_W-1:0] drv_a,
  output logic [CODE_W-1:0] drv_b,
  output logic              data_valid
);
  localparam int DEPTH = LAT - 1;
  localparam int NLANE = 2;

  oif_mode_e         mode;
  logic              load_word;
  logic [CODE_W-1:0] lane_in   [NLANE];
  logic [CODE_W-1:0] lane_tail [NLANE];
  logic [CODE_W-1:0] lane_out  [NLANE];

  assign mode       = pick_mode(sleep, pd);
  assign lane_in[0] = code_a;
  assign lane_in[1] = code_b;

  adc_oif_valid #(.LAT(LAT)) u_valid (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mode      (mode),
    .load_word (load_word),
    .dvalid    (data_valid)
  );

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      adc_oif_lane #(.W(CODE_W), .DEPTH(DEPTH)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_in   (lane_in[l]),
        .code_tail (lane_tail[l])
      );
      adc_oif_out #(.W(CODE_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .fmt_tc    (fmt_tc),
        .load_word (load_word),
        .code_tail (lane_tail[l]),
        .dout      (lane_out[l])
      );
    end
  endgenerate

  assign data_a = lane_out[0];
  assign data_b = lane_out[1];
  assign drv_a  = {CODE_W{~oe_n}};
  assign drv_b  = {CODE_W{~oe_n}};

  // R5: disabled drivers on both buses
  a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drv_a == '0 && drv_b == '0));

  // R7 / R6: no fresh word after an edge in sleep or power-down
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || pd) |=> !data_valid);

  // R9: with both levels high, both buses hold
  a_r9_pd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && sleep) |=> ($stable(data_a) && $stable(data_b)));
endmodule

// File: tb/sim_adc_oif_top.sv
module sim_adc_oif_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid;
  logic [9:0] code_a, code_b;
  logic       fmt_tc, oe_n, sleep, pd;
  logic [9:0] data_a, data_b, drv_a, drv_b;
  logic       data_valid;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_oif_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .code_a(code_a), .code_b(code_b),
    .fmt_tc(fmt_tc), .oe_n(oe_n), .sleep(sleep), .pd(pd),
    .data_a(data_a), .data_b(data_b), .drv_a(drv_a), .drv_b(drv_b), .data_valid(data_valid)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // present one sample for exactly one edge
  task automatic send(input logic [9:0] a, input logic [9:0] b);
    smp_valid = 1'b1; code_a = a; code_b = b;
    tick(1);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 data_a", data_a, 10'h000);
    chk("R11 data_b", data_b, 10'h000);
    chk("R11 valid", {9'd0, data_valid}, 10'd0);
    chk("R5 drv_a on", drv_a, 10'h3FF);
  endtask

  task automatic t_latency;
    send(10'h2A5, 10'h15A);
    tick(3);
    chk("R3 early valid", {9'd0, data_valid}, 10'd0);
    chk("R3 early data", data_a, 10'h000);
    tick(1);
    chk("R3 valid", {9'd0, data_valid}, 10'd1);
    chk("R1 lane A", data_a, 10'h2A5);
    chk("R1 lane B", data_b, 10'h15A);
    tick(1);
    chk("R4 valid drop", {9'd0, data_valid}, 10'd0);
    chk("R4 hold A", data_a, 10'h2A5);
  endtask

  task automatic t_format;
    fmt_tc = 1'b1;
    #1;
    chk("R10 not yet", data_a, 10'h2A5);
    tick(1);
    chk("R2 tc A", data_a, 10'h0A5);
    chk("R2 tc B", data_b, 10'h35A);
    send(10'h000, 10'h3FF);
    tick(4);
    chk("R2 zero tc", data_a, 10'h200);
    chk("R2 full tc", data_b, 10'h1FF);
    fmt_tc = 1'b0;
    tick(1);
    chk("R2 zero ob", data_a, 10'h000);
    chk("R2 full ob", data_b, 10'h3FF);
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    #1;
    chk("R5 drv_a off", drv_a, 10'h000);
    chk("R5 drv_b off", drv_b, 10'h000);
    tick(2);
    chk("R5 data kept", data_b, 10'h3FF);
    oe_n = 1'b0;
    #1;
    chk("R5 drv_b on", drv_b, 10'h3FF);
  endtask

  task automatic t_pd;
    send(10'h111, 10'h222);
    tick(3);
    pd = 1'b1;             // word due at the coming edge
    tick(1);
    chk("R6 arrival blocked", data_a, 10'h000);
    chk("R6 valid low", {9'd0, data_valid}, 10'd0);
    fmt_tc = 1'b1;
    tick(2);
    chk("R6 fmt ignored", data_a, 10'h000);
    oe_n = 1'b1;
    tick(1);
    chk("R6 oe off drv", drv_b, 10'h000);
    chk("R6 oe off data", data_b, 10'h3FF);
    oe_n = 1'b0; pd = 1'b0; fmt_tc = 1'b0;
    tick(1);
    chk("R8 no valid after pd", {9'd0, data_valid}, 10'd0);
    chk("R6 dropped word", data_a, 10'h000);
  endtask

  task automatic t_sleep;
    send(10'h0F0, 10'h30F);
    tick(1);
    sleep = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R7 no valid", {9'd0, data_valid}, 10'd0);
    end
    chk("R7 in-flight gone", data_a, 10'h000);
    fmt_tc = 1'b1;
    tick(1);
    chk("R7 recode A", data_a, 10'h200);
    chk("R7 recode B", data_b, 10'h1FF);
    fmt_tc = 1'b0;
    sleep = 1'b0;
    send(10'h155, 10'h2AA);
    tick(3);
    chk("R8 wait", {9'd0, data_valid}, 10'd0);
    tick(1);
    chk("R8 first fresh", {9'd0, data_valid}, 10'd1);
    chk("R8 data A", data_a, 10'h155);
    chk("R8 data B", data_b, 10'h2AA);
  endtask

  task automatic t_both;
    sleep = 1'b1; pd = 1'b1; fmt_tc = 1'b1;
    tick(2);
    chk("R9 frozen A", data_a, 10'h155);
    chk("R9 frozen B", data_b, 10'h2AA);
    pd = 1'b0;
    tick(1);
    chk("R9 sleep only recodes", data_a, 10'h355);
    chk("R9 sleep only B", data_b, 10'h0AA);
    sleep = 1'b0; fmt_tc = 1'b0;
    tick(1);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 4; i++) begin
      smp_valid = 1'b1;
      code_a = 10'(i * 37 + 5);
      code_b = 10'(1000 - i * 91);
      tick(1);
    end
    smp_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk("R1 stream A", data_a, 10'(i * 37 + 5));
      chk("R1 stream B", data_b, 10'(1000 - i * 91));
      chk("R3 stream valid", {9'd0, data_valid}, 10'd1);
    end
    tick(1);
    chk("R4 stream end", {9'd0, data_valid}, 10'd0);
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; code_a = '0; code_b = '0;
    fmt_tc = 1'b0; oe_n = 1'b0; sleep = 1'b0; pd = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_latency();
    t_format();
    t_oe();
    t_pd();
    t_sleep();
    t_both();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule